// File: doc/BRIEF.md
# Stack-Machine Control Transfer Unit

This unit owns the program counter and the return-stack pointer of a small stack processor. Its instructions are 16 bits wide and are fetched two to a 32-bit word. For each instruction handed to it, the unit picks the correct half of the fetched word and decodes the three control kinds. A relative branch always goes to its target. A conditional branch tests the top-of-stack value X and always pops. A transfer instruction can move the return pointer, load the PC from the return stack, save a return address, and jump to X. Call, return and indirect jump are all bit patterns of this one transfer encoding. Any other opcode just moves the PC forward by one instruction.

A transfer that reads or writes the return stack goes through a single-port data memory with a request/valid handshake. When one instruction both reads and writes, the read always comes first. The unit signals `done` for one cycle when the new PC and return pointer appear. A branch to itself (offset zero) raises a sticky `halt`, and only reset clears it.

Top module: `ctu_top`

## Requirements
- R1: After reset, `pc_o` is 0, `rp_o` is 65024, and `halt`, `done`, `x_gets_y` and `mem_req` are all low.
- R2: When `pc_o[1]` is 0, the instruction is `fetch_word[31:16]`; otherwise it is `fetch_word[15:0]`. Any opcode other than 000, 101 and 011 in instruction bits 15:13 moves the PC by +2, leaves `rp_o` unchanged and reports `sp_delta` = 00.
- R3: Opcode 000 sets the PC to the branch's own address plus the sign-extended 13-bit field in bits 12:0.
- R4: An opcode-000 instruction with a zero offset leaves the PC unchanged, completes with `done`, and sets `halt`. From then on `halt` stays high, `step` is ignored (no `done`, no PC or RP change) until reset.
- R5: Opcode 101 reads bit 0 as its polarity: 1 means branch when X is nonzero, 0 means branch when X is zero. When the branch is taken, the PC becomes its own address plus the sign-extended 13-bit offset with bit 0 cleared; otherwise the PC moves by +2. `sp_delta` reports 11 (pop).
- R6: Opcode 011 reads bits 9:8 as a sign-magnitude return delta (bit 9 sign, bit 8 magnitude). 01 adds 4 to `rp_o`, 11 subtracts 4, and 00 or 10 leave it unchanged. Bits 5:4 use the same coding and are reported on `sp_delta` as 01 (+1), 11 (-1) or 00.
- R7: A transfer with bit 7 set reads memory at the old return pointer, and the value read becomes the PC unless bit 0 is set.
- R8: A transfer with bit 6 set writes memory at the new return pointer. It writes the value read under R7 when bit 7 is set, and the instruction address +2 otherwise. The write is issued after the read.
- R9: A transfer with bit 0 set loads the PC from X and raises `x_gets_y` together with `done`. Bits 6 and 7 still take effect.
- R10: `done` is a one-cycle pulse. `pc_o` and `rp_o` change only in a cycle in which `done` is high.
- R11: A memory request holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stable until the cycle in which `mem_valid` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step | input | 1 | Execute the instruction at `pc_o` (accepted only while idle) |
| fetch_word | input | 32 | Word fetched from the word that holds `pc_o` |
| x_top | input | 32 | Top-of-stack value X |
| mem_req | output | 1 | Data memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the request |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_valid` |
| mem_valid | input | 1 | Memory completes the current request |
| pc_o | output | 32 | Program counter |
| rp_o | output | 32 | Return-stack pointer |
| done | output | 1 | Instruction finished; new PC and RP visible |
| halt | output | 1 | Sticky stop after a zero-offset branch |
| sp_delta | output | 2 | Evaluation-stack change, 2-bit two's complement, valid with `done` |
| x_gets_y | output | 1 | Pulses with `done` when Y must move into X |

## Verification
The bench builds the unit with its default values: 32-bit addresses, 16-bit instructions, a 13-bit offset field, PC reset 0 and RP reset 65024. These widths give the offset field its full negative range. They also make the return pointer wrap within the bench's 256-word memory window, so random calls and returns sometimes read back addresses saved earlier, and a read and a write can land on the same word. The memory model answers after a random wait of zero to two cycles, so the handshake is tested both with immediate answers and with waits.

// File: rtl/ctu_pkg.sv
// Package ctu_pkg
// Shared encodings for the control transfer unit: opcode values, the
// instruction-kind type, the sequencer state type and the sign-magnitude
// delta converter. Assumes 16-bit instructions whose top three bits are
// the opcode.
package ctu_pkg;

    localparam logic [2:0] OP_BRANCH = 3'b000;
    localparam logic [2:0] OP_CBRANCH = 3'b101;
    localparam logic [2:0] OP_XFER = 3'b011;

    // Bit positions inside a transfer instruction
    localparam int XB_RP_HI = 9;
    localparam int XB_RP_LO = 8;
    localparam int XB_LOAD = 7;
    localparam int XB_SAVE = 6;
    localparam int XB_SP_HI = 5;
    localparam int XB_SP_LO = 4;
    localparam int XB_JUMPX = 0;

    typedef enum logic [1:0] {
        K_OTHER,
        K_BRANCH,
        K_CBRANCH,
        K_XFER
    } ins_kind_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_READ,
        S_WRITE
    } seq_state_e;

    // Sign-magnitude 2-bit field to 2-bit two's complement (-0 becomes 0)
    function automatic logic [1:0] sm_to_tc(input logic [1:0] f);
        logic [1:0] r;
        case (f)
            2'b01: r = 2'b01;
            2'b11: r = 2'b11;
            default: r = 2'b00;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ctu_decode.sv
// Module ctu_decode
// Combinational decode. Picks the instruction half from PC bit 1, classifies
// the opcode, and works out the next PC for every case that needs no memory
// access, plus the transfer control bits. Assumes ADDR_W >= OFF_W + 2.
module ctu_decode
    import ctu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int INS_W = 16,
    parameter int OFF_W = 13
) (
    input  logic [ADDR_W-1:0]  pc_i,
    input  logic [2*INS_W-1:0] word_i,
    input  logic [ADDR_W-1:0]  x_i,
    output ins_kind_e          kind_o,
    output logic [ADDR_W-1:0]  next_pc_o,
    output logic               halt_req_o,
    output logic [1:0]         spd_o,
    output logic [1:0]         rpd_o,
    output logic               load_o,
    output logic               save_o,
    output logic               jumpx_o
);

    localparam int OP_W = INS_W - OFF_W;
    localparam int EXT_W = ADDR_W - OFF_W;

    logic [INS_W-1:0]  ins;
    logic [OP_W-1:0]   op;
    logic [ADDR_W-1:0] off_sx;
    logic [ADDR_W-1:0] seq_pc;
    logic              cond_hit;

    // Half-word select and field extraction
    always_comb begin
        ins = pc_i[1] ? word_i[INS_W-1:0] : word_i[2*INS_W-1:INS_W];
        op = ins[INS_W-1 -: OP_W];
        off_sx = {{EXT_W{ins[OFF_W-1]}}, ins[OFF_W-1:0]};
        seq_pc = pc_i + ADDR_W'(2);
        cond_hit = ins[0] ? (x_i != '0) : (x_i == '0);
    end

    // Opcode classification and next-PC selection
    always_comb begin
        kind_o = K_OTHER;
        next_pc_o = seq_pc;
        halt_req_o = 1'b0;
        spd_o = 2'b00;
        rpd_o = 2'b00;
        load_o = 1'b0;
        save_o = 1'b0;
        jumpx_o = 1'b0;
        case (op)
            OP_BRANCH: begin
                kind_o = K_BRANCH;
                next_pc_o = pc_i + off_sx;
                halt_req_o = (ins[OFF_W-1:0] == '0);
            end
            OP_CBRANCH: begin
                kind_o = K_CBRANCH;
                spd_o = 2'b11;
                if (cond_hit) begin
                    next_pc_o = pc_i + {off_sx[ADDR_W-1:1], 1'b0};
                end
            end
            OP_XFER: begin
                kind_o = K_XFER;
                spd_o = sm_to_tc(ins[XB_SP_HI:XB_SP_LO]);
                rpd_o = sm_to_tc(ins[XB_RP_HI:XB_RP_LO]);
                load_o = ins[XB_LOAD];
                save_o = ins[XB_SAVE];
                jumpx_o = ins[XB_JUMPX];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ctu_seq.sv
// Module ctu_seq
// Instruction sequencer. Accepts a step while idle. It either finishes in the
// same cycle or walks the read and then the write of the return stack
// through the request/valid handshake. It presents one commit pulse with the
// new PC and RP. Assumes the memory holds the request until it raises valid.
module ctu_seq
    import ctu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              halted_i,
    input  ins_kind_e         kind_i,
    input  logic [ADDR_W-1:0] next_pc_i,
    input  logic              halt_req_i,
    input  logic [1:0]        spd_i,
    input  logic [1:0]        rpd_i,
    input  logic              load_i,
    input  logic              save_i,
    input  logic              jumpx_i,
    input  logic [ADDR_W-1:0] x_i,
    input  logic [ADDR_W-1:0] rp_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [ADDR_W-1:0] mem_wdata_o,
    input  logic [ADDR_W-1:0] mem_rdata_i,
    input  logic              mem_valid_i,
    output logic              commit_o,
    output logic [ADDR_W-1:0] cpc_o,
    output logic [ADDR_W-1:0] crp_o,
    output logic              chalt_o,
    output logic [1:0]        cspd_o,
    output logic              cxy_o
);

    seq_state_e        st_q, st_d;
    logic [ADDR_W-1:0] h_pc_q, h_pc_d;
    logic [ADDR_W-1:0] h_old_rp_q, h_new_rp_q;
    logic [ADDR_W-1:0] h_x_q;
    logic              h_save_q, h_jumpx_q;
    logic [1:0]        h_spd_q;
    logic [ADDR_W-1:0] new_rp;
    logic              go, is_xfer, needs_mem;

    // Return-pointer arithmetic: delta in words scaled to bytes
    always_comb begin
        new_rp = rp_i + {{(ADDR_W-4){rpd_i[1]}}, rpd_i, 2'b00};
        go = step_i && !halted_i && (st_q == S_IDLE);
        is_xfer = (kind_i == K_XFER);
        needs_mem = is_xfer && (load_i || save_i);
    end

    // Next state, memory request and commit outputs
    always_comb begin
        st_d = st_q;
        h_pc_d = h_pc_q;
        mem_req_o = 1'b0;
        mem_we_o = 1'b0;
        mem_addr_o = h_old_rp_q;
        mem_wdata_o = h_pc_q;
        commit_o = 1'b0;
        cpc_o = h_jumpx_q ? h_x_q : h_pc_q;
        crp_o = h_new_rp_q;
        chalt_o = 1'b0;
        cspd_o = h_spd_q;
        cxy_o = h_jumpx_q;
        case (st_q)
            S_IDLE: begin
                if (go && needs_mem) begin
                    h_pc_d = next_pc_i;
                    st_d = load_i ? S_READ : S_WRITE;
                end else if (go) begin
                    commit_o = 1'b1;
                    cpc_o = (is_xfer && jumpx_i) ? x_i : next_pc_i;
                    crp_o = is_xfer ? new_rp : rp_i;
                    chalt_o = halt_req_i;
                    cspd_o = spd_i;
                    cxy_o = is_xfer && jumpx_i;
                end
            end
            S_READ: begin
                mem_req_o = 1'b1;
                mem_addr_o = h_old_rp_q;
                if (mem_valid_i) begin
                    h_pc_d = mem_rdata_i;
                    if (h_save_q) begin
                        st_d = S_WRITE;
                    end else begin
                        st_d = S_IDLE;
                        commit_o = 1'b1;
                        cpc_o = h_jumpx_q ? h_x_q : mem_rdata_i;
                    end
                end
            end
            S_WRITE: begin
                mem_req_o = 1'b1;
                mem_we_o = 1'b1;
                mem_addr_o = h_new_rp_q;
                if (mem_valid_i) begin
                    st_d = S_IDLE;
                    commit_o = 1'b1;
                end
            end
            default: st_d = S_IDLE;
        endcase
    end

    // Sequencer state and per-instruction hold registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= S_IDLE;
            h_pc_q <= '0;
            h_old_rp_q <= '0;
            h_new_rp_q <= '0;
            h_x_q <= '0;
            h_save_q <= 1'b0;
            h_jumpx_q <= 1'b0;
            h_spd_q <= 2'b00;
        end else begin
            st_q <= st_d;
            h_pc_q <= h_pc_d;
            if (go && needs_mem) begin
                h_old_rp_q <= rp_i;
                h_new_rp_q <= new_rp;
                h_x_q <= x_i;
                h_save_q <= save_i;
                h_jumpx_q <= jumpx_i;
                h_spd_q <= spd_i;
            end
        end
    end

endmodule

// File: rtl/ctu_regs.sv
// Module ctu_regs
// Architectural registers: PC, return pointer, sticky halt, and the
// per-instruction result pulses. Updated only by a commit from the sequencer.
module ctu_regs #(
    parameter int ADDR_W = 32,
    parameter logic [ADDR_W-1:0] PC_RESET = '0,
    parameter logic [ADDR_W-1:0] RP_RESET = ADDR_W'(65024)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic [ADDR_W-1:0] cpc_i,
    input  logic [ADDR_W-1:0] crp_i,
    input  logic              chalt_i,
    input  logic [1:0]        cspd_i,
    input  logic              cxy_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] rp_o,
    output logic              halt_o,
    output logic              done_o,
    output logic [1:0]        spd_o,
    output logic              xy_o
);

    // Register update on commit, sticky halt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_o <= PC_RESET;
            rp_o <= RP_RESET;
            halt_o <= 1'b0;
            done_o <= 1'b0;
            spd_o <= 2'b00;
            xy_o <= 1'b0;
        end else begin
            done_o <= commit_i;
            xy_o <= commit_i && cxy_i;
            halt_o <= halt_o || (commit_i && chalt_i);
            if (commit_i) begin
                pc_o <= cpc_i;
                rp_o <= crp_i;
                spd_o <= cspd_i;
            end
        end
    end

endmodule

// File: rtl/ctu_top.sv
// Module ctu_top
// Control transfer unit for a stack CPU with two 16-bit instructions per
// 32-bit word. Combines decode, sequencer and architectural registers.
// Assumes fetch_word is the word holding pc_o whenever step is high.
module ctu_top #(
    parameter int ADDR_W = 32,
    parameter int INS_W = 16,
    parameter int OFF_W = 13,
    parameter logic [ADDR_W-1:0] PC_RESET = '0,
    parameter logic [ADDR_W-1:0] RP_RESET = ADDR_W'(65024)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [2*INS_W-1:0] fetch_word,
    input  logic [ADDR_W-1:0] x_top,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] mem_wdata,
    input  logic [ADDR_W-1:0] mem_rdata,
    input  logic              mem_valid,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] rp_o,
    output logic              done,
    output logic              halt,
    output logic [1:0]        sp_delta,
    output logic              x_gets_y
);

    ctu_pkg::ins_kind_e kind;
    logic [ADDR_W-1:0]  next_pc, cpc, crp;
    logic               halt_req, load, save, jumpx;
    logic               commit, chalt, cxy;
    logic [1:0]         spd, rpd, cspd;

    ctu_decode #(.ADDR_W(ADDR_W), .INS_W(INS_W), .OFF_W(OFF_W)) i_decode (
        .pc_i(pc_o), .word_i(fetch_word), .x_i(x_top),
        .kind_o(kind), .next_pc_o(next_pc), .halt_req_o(halt_req),
        .spd_o(spd), .rpd_o(rpd), .load_o(load), .save_o(save), .jumpx_o(jumpx)
    );

    ctu_seq #(.ADDR_W(ADDR_W)) i_seq (
        .clk(clk), .rst_n(rst_n), .step_i(step), .halted_i(halt),
        .kind_i(kind), .next_pc_i(next_pc), .halt_req_i(halt_req),
        .spd_i(spd), .rpd_i(rpd), .load_i(load), .save_i(save), .jumpx_i(jumpx),
        .x_i(x_top), .rp_i(rp_o),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_valid_i(mem_valid),
        .commit_o(commit), .cpc_o(cpc), .crp_o(crp), .chalt_o(chalt),
        .cspd_o(cspd), .cxy_o(cxy)
    );

    ctu_regs #(.ADDR_W(ADDR_W), .PC_RESET(PC_RESET), .RP_RESET(RP_RESET)) i_regs (
        .clk(clk), .rst_n(rst_n), .commit_i(commit), .cpc_i(cpc), .crp_i(crp),
        .chalt_i(chalt), .cspd_i(cspd), .cxy_i(cxy),
        .pc_o(pc_o), .rp_o(rp_o), .halt_o(halt), .done_o(done),
        .spd_o(sp_delta), .xy_o(x_gets_y)
    );

endmodule

// File: rtl/ctu_checker.sv
// Module ctu_checker
// Temporal properties of the control transfer unit, attached by bind.
module ctu_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] pc_o,
    input logic [ADDR_W-1:0] rp_o,
    input logic              done,
    input logic              halt,
    input logic              x_gets_y,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] mem_wdata,
    input logic              mem_valid
);

    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_we)
            && $stable(mem_addr) && $stable(mem_wdata)));

    p_halt_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> halt);

    p_halt_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (!done && $stable(pc_o) && $stable(rp_o)));

    p_change_on_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (done || ($stable(pc_o) && $stable(rp_o))));

    p_rp_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((rp_o == $past(rp_o)) || (rp_o == $past(rp_o) + ADDR_W'(4))
            || (rp_o == $past(rp_o) - ADDR_W'(4))));

    p_xy_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        x_gets_y |-> done);

endmodule

bind ctu_top ctu_checker #(.ADDR_W(ADDR_W)) i_ctu_checker (
    .clk(clk), .rst_n(rst_n), .pc_o(pc_o), .rp_o(rp_o), .done(done),
    .halt(halt), .x_gets_y(x_gets_y), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_valid(mem_valid)
);

// File: tb/test_ctu_top.sv
`timescale 1ns/1ps
module test_ctu_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step = 1'b0;
    logic [31:0] fetch_word = '0;
    logic [31:0] x_top = '0;
    logic        mem_req, mem_we, mem_valid;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [31:0] pc_o, rp_o;
    logic        done, halt, x_gets_y;
    logic [1:0]  sp_delta;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [31:0] tmem [256];
    int unsigned lat = 0;

    logic [31:0] ref_pc, ref_rp;
    logic        ref_halt;

    always #2.5 clk = ~clk;

    ctu_top i_ctu_top (
        .clk(clk), .rst_n(rst_n), .step(step), .fetch_word(fetch_word),
        .x_top(x_top), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_valid(mem_valid),
        .pc_o(pc_o), .rp_o(rp_o), .done(done), .halt(halt),
        .sp_delta(sp_delta), .x_gets_y(x_gets_y)
    );

    assign mem_rdata = tmem[mem_addr[9:2]];

    // Memory model with random response latency
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_valid <= 1'b0;
            lat = 0;
        end else if (mem_valid) begin
            if (mem_we) tmem[mem_addr[9:2]] <= mem_wdata;
            mem_valid <= 1'b0;
        end else if (mem_req) begin
            if (lat == 0) begin
                mem_valid <= 1'b1;
                lat = $urandom_range(0, 2);
            end else begin
                lat = lat - 1;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] sx13(input logic [12:0] f);
        return {{19{f[12]}}, f};
    endfunction

    function automatic logic [1:0] smc(input logic [1:0] f);
        return (f == 2'b01) ? 2'b01 : ((f == 2'b11) ? 2'b11 : 2'b00);
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        step = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        ref_pc = 32'd0;
        ref_rp = 32'd65024;
        ref_halt = 1'b0;
        @(negedge clk);
        chk("R1 pc", pc_o, 32'd0);
        chk("R1 rp", rp_o, 32'd65024);
        chk("R1 halt/done/xy/req", {28'd0, halt, done, x_gets_y, mem_req}, 32'd0);
    endtask

    task automatic do_step(input logic [15:0] ins, input logic [31:0] x);
        logic [31:0] epc, erp, rv, after, pc0;
        logic [1:0]  espd;
        logic        exy, ehalt, wr, got;
        logic [7:0]  widx;
        logic [15:0] other;
        pc0 = ref_pc;
        epc = ref_pc + 32'd2;
        erp = ref_rp;
        espd = 2'b00;
        exy = 1'b0;
        ehalt = ref_halt;
        wr = 1'b0;
        widx = '0;
        after = '0;
        case (ins[15:13])
            3'b000: begin
                epc = ref_pc + sx13(ins[12:0]);
                if (ins[12:0] == 13'd0) ehalt = 1'b1;
            end
            3'b101: begin
                espd = 2'b11;
                if (ins[0] ? (x != 0) : (x == 0))
                    epc = ref_pc + (sx13(ins[12:0]) & ~32'd1);
            end
            3'b011: begin
                espd = smc(ins[5:4]);
                if (ins[9:8] == 2'b01) erp = ref_rp + 32'd4;
                if (ins[9:8] == 2'b11) erp = ref_rp - 32'd4;
                rv = tmem[ref_rp[9:2]];
                after = ins[7] ? rv : ref_pc + 32'd2;
                epc = ins[0] ? x : after;
                exy = ins[0];
                wr = ins[6];
                widx = erp[9:2];
            end
            default: ;
        endcase
        other = 16'($urandom);
        @(negedge clk);
        fetch_word = ref_pc[1] ? {other, ins} : {ins, other};
        x_top = x;
        step = 1'b1;
        @(posedge clk);
        #1 step = 1'b0;
        if (ref_halt) begin
            got = 1'b0;
            repeat (10) begin
                @(negedge clk);
                if (done) got = 1'b1;
            end
            chk("R4 no done while halted", {31'd0, got}, 32'd0);
            chk("R4 pc frozen", pc_o, pc0);
            chk("R4 halt stays", {31'd0, halt}, 32'd1);
            return;
        end
        got = 1'b0;
        for (int n = 0; n < 50; n++) begin
            @(negedge clk);
            if (done) begin
                got = 1'b1;
                break;
            end
        end
        chk("R10 done seen", {31'd0, got}, 32'd1);
        case (ins[15:13])
            3'b000: chk("R3 branch pc", pc_o, epc);
            3'b101: chk("R5 cbranch pc", pc_o, epc);
            3'b011: chk(ins[0] ? "R9 jump pc" : "R7 xfer pc", pc_o, epc);
            default: chk("R2 seq pc", pc_o, epc);
        endcase
        chk("R6 rp", rp_o, erp);
        chk("R6 sp_delta", {30'd0, sp_delta}, {30'd0, espd});
        chk("R9 x_gets_y", {31'd0, x_gets_y}, {31'd0, exy});
        chk("R4 halt", {31'd0, halt}, {31'd0, ehalt});
        if (wr) chk("R8 saved word", tmem[widx], after);
        @(negedge clk);
        chk("R10 done one cycle", {31'd0, done}, 32'd0);
        ref_pc = epc;
        ref_rp = erp;
        ref_halt = ehalt;
    endtask

    initial begin
        #(5.0 * 190000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] ins;
        void'($urandom(32'd1234));
        for (int i = 0; i < 256; i++) tmem[i] = $urandom;
        do_reset();

        // R2: upper half at pc%4==0, then lower half
        do_step(16'h8123, 32'd5);
        do_step(16'h2000, 32'd5);
        // R3: forward and backward branch
        do_step(16'h0040, 32'd0);
        do_step(16'h1FF0, 32'd0);
        // R5: both polarities, taken and not taken, odd offset bit cleared
        do_step(16'hA011, 32'd7);
        do_step(16'hA011, 32'd0);
        do_step(16'hA020, 32'd0);
        do_step(16'hA020, 32'd3);
        // R9/R8: call = rp +1, sp -1, save, jump to X
        do_step(16'h6171, 32'h0000_2468);
        // R7: return = rp -1, load
        do_step(16'h6380, 32'd0);
        // R7/R8: load and save in the same instruction, sp +1
        do_step(16'h60D0, 32'd0);
        // R6: negative zero leaves rp unchanged, indirect jump
        do_step(16'h6231, 32'h0000_1000);

        for (int k = 0; k < 400; k++) begin
            case ($urandom % 4)
                0: begin
                    ins = {3'b000, 13'($urandom)};
                    if (ins[12:0] == 0) ins[1] = 1'b1;
                end
                1: ins = {3'b101, 13'($urandom)};
                2: ins = {3'b011, 13'($urandom)};
                default: ins = {3'b100, 13'($urandom)};
            endcase
            do_step(ins, ($urandom % 3 == 0) ? 32'd0 : {$urandom} & ~32'd1);
        end

        // R4: zero-offset branch halts; later steps are ignored
        do_step(16'h0000, 32'd0);
        do_step(16'h2000, 32'd1);
        do_step(16'h6171, 32'd8);
        // R1: reset clears halt
        do_reset();
        do_step(16'h4002, 32'd0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule